// File: doc/BRIEF.md
# Dual-Stage Timebase Watchdog

This block is a register-mapped watchdog for a system-on-chip. A free-running 32-bit timebase counter runs beside a separate interval counter. The interval counter advances only while two enable bits are both set, and these bits live in two different registers. Each interval lasts 2^W clock cycles, where W is a programmable width between 8 and a build-time maximum.

When the first interval ends, the block sets a state flag and drives its interrupt line. If a second interval ends and software has still not cleared the flag, the block issues a one-cycle system reset request and latches a reset-cause bit. That bit is held in logic reset only by the power-on reset, so it survives the system reset the request triggers. Software feeds the watchdog by writing one to the state flag. An optional build-time lock stops software from disabling the watchdog once it has been armed.

The register bus is a plain single-cycle interface with address, write strobe, write data and combinational read data. Register selection uses byte offsets 0x0, 0x4, 0x8 and 0xC through address bits [3:2].

Top module: `dual_stage_wdt`

## Requirements
- R1: After power-on reset, offsets 0x0 and 0x4 read zero and the width register at 0xC reads 8.
- R2: The timebase at offset 0x8 increases by exactly one each clock cycle. Writes to 0x8 do not change it.
- R3: The interval counter advances only while both enables are set. Enable A is bit 1 of offset 0x0. Enable B can be written through bit 0 of 0x0 or bit 0 of 0x4, and it reads back identically at both places.
- R4: A width write below 8 stores 8, and a width write above WIDTH_MAX stores WIDTH_MAX. Other values are stored as written.
- R5: 2^W cycles after the enable edge, the state flag (bit 2 of 0x0) sets and `irq` goes high. `irq` stays high while the flag is set.
- R6: If a second interval ends while the flag is still set, `rst_req` is high for exactly one cycle. This happens 2^(W+1) cycles after the enable edge.
- R7: Writing 1 to bit 2 of 0x0 clears the flag and restarts the interval. A feed in the same cycle as an interval end wins, and no reset request follows.
- R8: Clearing either enable holds the interval counter at zero. Re-enabling starts a full, fresh interval.
- R9: A width written while the watchdog runs is used from the next interval restart onward. The interval already in progress keeps its old length.
- R10: A reset request sets the cause bit (bit 3 of 0x0). The bit survives `sys_rst_n`, and it is cleared by writing 1 to it or by `por_n`.
- R11: With ENABLE_ONCE set, once both enables have been set, writes cannot clear either one until a reset.
- R12: `sys_rst_n` returns every register except the cause bit to its power-on value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low power-on reset; clears everything including the cause bit |
| sys_rst_n | input | 1 | Active-low system reset; clears everything except the cause bit |
| bus_addr | input | 4 | Byte address; bits [3:2] select the register |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| irq | output | 1 | High while the state flag is set |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench places every interrupt edge and every reset pulse on an exact cycle, so an off-by-one in the wrap compare or in counter clearing shifts an event and is reported.

Feeding on the very edge of the second wrap separates feed-over-wrap priority. A design with the wrong priority would pulse the reset.

Disabling in mid-interval and then re-enabling shows whether the counter was zeroed or only frozen; a frozen counter fires the interrupt early. Changing the width in mid-interval catches a design that applies the new width at once, because its first interrupt comes late.

The cause bit is read across a system reset and then a power-on reset, which exposes a bit placed in the wrong reset domain. The lock instance is given writes that try to clear each enable.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int W_MIN   = 8;
  localparam int BUS_W   = 32;
  localparam int ADDR_W  = 4;

  localparam int B_CAUSE = 3;
  localparam int B_FLAG  = 2;
  localparam int B_EN_A  = 1;
  localparam int B_EN_B  = 0;

  typedef enum logic [1:0] {
    SEL_CTRL0 = 2'd0,
    SEL_CTRL1 = 2'd1,
    SEL_TBASE = 2'd2,
    SEL_WIDTH = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/wdt_timebase.sv
module wdt_timebase #(
  parameter int TB_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TB_W-1:0] tb_o
);
  logic [TB_W-1:0] tb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) tb_q <= '0;
    else        tb_q <= tb_q + TB_W'(1);
  end

  assign tb_o = tb_q;

  // R2: strictly one step per clock
  a_r2_tb_step: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> tb_q == $past(tb_q) + TB_W'(1));
endmodule

// File: rtl/wdt_interval.sv
module wdt_interval import wdt_pkg::*; #(
  parameter int WIDTH_MAX = 24,
  localparam int CW = WIDTH_MAX,
  localparam int WW = $clog2(WIDTH_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          feed_i,
  input  logic [WW-1:0] width_i,
  output logic          flag_o,
  output logic          rst_req_o
);
  logic [CW-1:0] cnt_q;
  logic [WW-1:0] act_w_q;
  logic          flag_q;
  logic          rst_req_q;
  logic [CW:0]   one_sh;
  logic [CW-1:0] mask;
  logic          wrap;
  logic          restart;

  always_comb begin
    one_sh  = (CW + 1)'(1) << act_w_q;
    mask    = one_sh[CW-1:0] - CW'(1);
    wrap    = run_i && (cnt_q == mask);
    restart = !run_i || feed_i || wrap;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      act_w_q   <= WW'(W_MIN);
      flag_q    <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= 1'b0;
      if (restart) cnt_q <= '0;
      else         cnt_q <= cnt_q + CW'(1);
      if (restart) act_w_q <= width_i;
      if (feed_i) begin
        flag_q <= 1'b0;
      end else if (wrap) begin
        if (flag_q) rst_req_q <= 1'b1;
        else        flag_q    <= 1'b1;
      end
    end
  end

  assign flag_o    = flag_q;
  assign rst_req_o = rst_req_q;

  // R6: request lasts one cycle and only ever follows a set flag
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |=> !rst_req_q);
  a_r6_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |-> flag_q);
  // R7: a feed leaves neither flag nor request behind
  a_r7_feed_wins: assert property (@(posedge clk) disable iff (!rst_n)
    feed_i |=> (!flag_q && !rst_req_q));
  // R8: idle counter sits at zero
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs import wdt_pkg::*; #(
  parameter int WIDTH_MAX   = 24,
  parameter bit ENABLE_ONCE = 1'b0,
  localparam int WW = $clog2(WIDTH_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_n,
  input  logic             wr_i,
  input  reg_sel_e         sel_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic             rst_req_i,
  input  logic             flag_i,
  input  logic [BUS_W-1:0] tb_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic             run_o,
  output logic             feed_o,
  output logic [WW-1:0]    width_o
);
  logic          en_a_q, en_b_q, en_a_d, en_b_d;
  logic          cause_q;
  logic [WW-1:0] width_q, w_clamp;
  logic          locked;
  logic          wr_c0, wr_c1;

  assign wr_c0  = wr_i && (sel_i == SEL_CTRL0);
  assign wr_c1  = wr_i && (sel_i == SEL_CTRL1);
  assign locked = ENABLE_ONCE && en_a_q && en_b_q;

  always_comb begin
    en_a_d = en_a_q;
    en_b_d = en_b_q;
    if (wr_c0) begin
      en_a_d = wdata_i[B_EN_A];
      en_b_d = wdata_i[B_EN_B];
    end else if (wr_c1) begin
      en_b_d = wdata_i[B_EN_B];
    end
    if (locked) begin
      en_a_d = en_a_d | en_a_q;
      en_b_d = en_b_d | en_b_q;
    end
  end

  always_comb begin
    if (wdata_i < BUS_W'(W_MIN))          w_clamp = WW'(W_MIN);
    else if (wdata_i > BUS_W'(WIDTH_MAX)) w_clamp = WW'(WIDTH_MAX);
    else                                  w_clamp = wdata_i[WW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_a_q  <= 1'b0;
      en_b_q  <= 1'b0;
      width_q <= WW'(W_MIN);
    end else begin
      en_a_q <= en_a_d;
      en_b_q <= en_b_d;
      if (wr_i && (sel_i == SEL_WIDTH)) width_q <= w_clamp;
    end
  end

  // cause bit lives only in the power-on domain
  always_ff @(posedge clk) begin
    if (!por_n)                          cause_q <= 1'b0;
    else if (rst_req_i)                  cause_q <= 1'b1;
    else if (wr_c0 && wdata_i[B_CAUSE])  cause_q <= 1'b0;
  end

  always_comb begin
    unique case (sel_i)
      SEL_CTRL0: rdata_o = BUS_W'({cause_q, flag_i, en_a_q, en_b_q});
      SEL_CTRL1: rdata_o = BUS_W'(en_b_q);
      SEL_TBASE: rdata_o = tb_i;
      default:   rdata_o = BUS_W'(width_q);
    endcase
  end

  assign run_o   = en_a_q && en_b_q;
  assign feed_o  = wr_c0 && wdata_i[B_FLAG];
  assign width_o = width_q;

  // R4: stored width always legal
  a_r4_width_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (width_q >= WW'(W_MIN)) && (width_q <= WW'(WIDTH_MAX)));
  // R10: a request always leaves the cause bit set
  a_r10_cause_set: assert property (@(posedge clk) disable iff (!por_n)
    rst_req_i |=> cause_q);

  generate
    if (ENABLE_ONCE) begin : g_lock_chk
      // R11: armed watchdog stays armed
      a_r11_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (en_a_q && en_b_q) |=> (en_a_q && en_b_q));
    end
  endgenerate
endmodule

// File: rtl/dual_stage_wdt.sv
module dual_stage_wdt import wdt_pkg::*; #(
  parameter int WIDTH_MAX   = 24,
  parameter bit ENABLE_ONCE = 1'b0
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        sys_rst_n,
  input  logic [3:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        rst_req
);
  localparam int WW = $clog2(WIDTH_MAX + 1);

  logic             rst_n;
  reg_sel_e         sel;
  logic [BUS_W-1:0] tb;
  logic             run, feed, flag;
  logic [WW-1:0]    width;
  logic [1:0]       unused_lo;

  assign rst_n     = por_n && sys_rst_n;
  assign sel       = reg_sel_e'(bus_addr[3:2]);
  assign unused_lo = bus_addr[1:0];

  wdt_timebase #(.TB_W(BUS_W)) u_tb (
    .clk  (clk),
    .rst_n(rst_n),
    .tb_o (tb)
  );

  wdt_regs #(.WIDTH_MAX(WIDTH_MAX), .ENABLE_ONCE(ENABLE_ONCE)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .por_n    (por_n),
    .wr_i     (bus_wr),
    .sel_i    (sel),
    .wdata_i  (bus_wdata),
    .rst_req_i(rst_req),
    .flag_i   (flag),
    .tb_i     (tb),
    .rdata_o  (bus_rdata),
    .run_o    (run),
    .feed_o   (feed),
    .width_o  (width)
  );

  wdt_interval #(.WIDTH_MAX(WIDTH_MAX)) u_ivl (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run),
    .feed_i   (feed),
    .width_i  (width),
    .flag_o   (flag),
    .rst_req_o(rst_req)
  );

  assign irq = flag;
endmodule

// File: tb/dual_stage_wdt_tb.sv
module dual_stage_wdt_tb;
  localparam int WMAX = 24;
  localparam logic [3:0] A_C0 = 4'h0, A_C1 = 4'h4, A_TB = 4'h8, A_W = 4'hC;
  localparam int K_IRQ = 0, K_RST = 1;

  logic clk = 1'b0;
  logic por_n = 1'b0, sys_rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0, wr_once = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_once;
  logic irq, rst_req, irq_once, rst_once;

  always #4 clk = ~clk;

  dual_stage_wdt #(.WIDTH_MAX(WMAX), .ENABLE_ONCE(1'b0)) u_dut (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .bus_addr(addr),
    .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq), .rst_req(rst_req));

  dual_stage_wdt #(.WIDTH_MAX(WMAX), .ENABLE_ONCE(1'b1)) u_dut_once (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .bus_addr(addr),
    .bus_wr(wr_once), .bus_wdata(wdata), .bus_rdata(rdata_once), .irq(irq_once),
    .rst_req(rst_once));

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int kind; longint at; string req; } exp_t;
  exp_t q[$];
  int errors = 0, checks = 0;
  bit irq_prev = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic push(int kind, longint at, string req);
    exp_t e;
    e.kind = kind; e.at = at; e.req = req;
    q.push_back(e);
  endtask

  task automatic seen(int kind);
    exp_t e;
    checks++;
    if (q.size() == 0) begin
      errors++;
      $display("FAIL unexpected event: actual=kind %0d at cycle %0d expected=none", kind, cyc);
    end else begin
      e = q.pop_front();
      if (e.kind != kind || e.at != cyc) begin
        errors++;
        $display("FAIL %s: actual=kind %0d at cycle %0d expected=kind %0d at cycle %0d",
                 e.req, kind, cyc, e.kind, e.at);
      end
    end
  endtask

  // monitor: scoreboard side
  always @(negedge clk) begin
    if (por_n && sys_rst_n) begin
      if (irq && !irq_prev) seen(K_IRQ);
      if (rst_req) seen(K_RST);
    end
    irq_prev = irq;
  end

  task automatic wr_reg(logic [3:0] a, logic [31:0] d, bit once = 1'b0);
    @(negedge clk);
    addr = a; wdata = d;
    if (once) wr_once = 1'b1; else wr = 1'b1;
    @(posedge clk); #1;
    wr = 1'b0; wr_once = 1'b0;
  endtask

  task automatic rd_reg(logic [3:0] a, output logic [31:0] d, input bit once = 1'b0);
    @(negedge clk);
    addr = a; #1;
    d = once ? rdata_once : rdata;
  endtask

  task automatic wait_until(longint n);
    while (cyc < n) begin @(posedge clk); #1; end
  endtask

  task automatic pulse_sys();
    @(negedge clk); sys_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    sys_rst_n = 1'b1;
  endtask

  task automatic pulse_por();
    @(negedge clk); por_n = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] d, t0, t1;
    longint c, c0, c1, cf, cf2, ca, cb;

    repeat (4) @(negedge clk);
    por_n = 1'b1; sys_rst_n = 1'b1;

    // R1 reset state
    rd_reg(A_C0, d); chk("R1 ctrl0", d, 32'h0);
    rd_reg(A_C1, d); chk("R1 ctrl1", d, 32'h0);
    rd_reg(A_W, d);  chk("R1 width", d, 32'd8);

    // R2 timebase steps per clock and ignores writes
    rd_reg(A_TB, t0); c0 = cyc;
    wr_reg(A_TB, 32'h0);
    repeat (10) @(posedge clk);
    rd_reg(A_TB, t1); c1 = cyc;
    chk("R2 timebase", t1 - t0, 32'(c1 - c0));

    // R4 clamping
    wr_reg(A_W, 32'd3);   rd_reg(A_W, d); chk("R4 clamp low", d, 32'd8);
    wr_reg(A_W, 32'd100); rd_reg(A_W, d); chk("R4 clamp high", d, 32'(WMAX));
    wr_reg(A_W, 32'd12);  rd_reg(A_W, d); chk("R4 in range", d, 32'd12);
    wr_reg(A_W, 32'd8);

    // R3 alias of enable B, no counting with one enable
    wr_reg(A_C1, 32'h1);
    rd_reg(A_C0, d); chk("R3 alias in ctrl0", d, 32'h1);
    rd_reg(A_C1, d); chk("R3 ctrl1 readback", d, 32'h1);
    repeat (600) @(posedge clk);
    wr_reg(A_C0, 32'h2);
    rd_reg(A_C1, d); chk("R3 ctrl0 write clears B", d, 32'h0);
    repeat (600) @(posedge clk);
    rd_reg(A_C0, d); chk("R3 no flag with one enable", d, 32'h2);

    // R5/R6 two-stage expiry
    wr_reg(A_C1, 32'h1); c = cyc;
    push(K_IRQ, c + 256, "R5 first wrap");
    push(K_RST, c + 512, "R6 second wrap");
    wait_until(c + 520);
    rd_reg(A_C0, d); chk("R10 cause flag enables", d, 32'hF);

    // R10/R12 system reset keeps only the cause
    pulse_sys();
    rd_reg(A_C0, d); chk("R10 cause survives sys reset", d, 32'h8);
    rd_reg(A_C1, d); chk("R12 ctrl1 after sys reset", d, 32'h0);
    wr_reg(A_C0, 32'h8);
    rd_reg(A_C0, d); chk("R10 write one clears cause", d, 32'h0);

    // R7 feed
    wr_reg(A_C1, 32'h1);
    wr_reg(A_C0, 32'h7); c = cyc;
    push(K_IRQ, c + 256, "R5 irq before feed");
    wait_until(c + 300);
    wr_reg(A_C0, 32'h7); cf = cyc;
    rd_reg(A_C0, d); chk("R7 feed clears flag", d, 32'h3);
    push(K_IRQ, cf + 256, "R7 restarted interval");
    wait_until(cf + 511);
    wr_reg(A_C0, 32'h7); cf2 = cyc;   // feed on the second-wrap edge
    chk("R7 feed on wrap edge", 32'(cf2), 32'(cf + 512));
    push(K_IRQ, cf2 + 256, "R7 feed beat wrap");
    wait_until(cf2 + 300);
    wr_reg(A_C0, 32'h4);
    rd_reg(A_C0, d); chk("R7 feed and disable", d, 32'h0);

    // R8 disable zeroes the counter
    wr_reg(A_C1, 32'h1);
    wr_reg(A_C0, 32'h7); ca = cyc;
    wait_until(ca + 200);
    wr_reg(A_C1, 32'h0);
    rd_reg(A_C0, d); chk("R8 enable B cleared", d, 32'h2);
    repeat (400) @(posedge clk);
    wr_reg(A_C1, 32'h1); cb = cyc;
    push(K_IRQ, cb + 256, "R8 fresh interval");
    wait_until(cb + 300);
    wr_reg(A_C0, 32'h4);

    // R9 width change mid-interval
    wr_reg(A_C1, 32'h1);
    wr_reg(A_C0, 32'h7); c = cyc;
    wait_until(c + 100);
    wr_reg(A_W, 32'd9);
    push(K_IRQ, c + 256, "R9 old width kept");
    push(K_RST, c + 768, "R9 new width after restart");
    wait_until(c + 780);
    rd_reg(A_W, d); chk("R9 width readback", d, 32'd9);
    pulse_sys();
    rd_reg(A_C0, d); chk("R10 cause after second expiry", d, 32'h8);
    rd_reg(A_W, d);  chk("R12 width after sys reset", d, 32'd8);
    pulse_por();
    rd_reg(A_C0, d); chk("R10 por clears cause", d, 32'h0);

    // R11 enable-once lock
    wr_reg(A_C0, 32'h2, 1'b1);
    wr_reg(A_C0, 32'h0, 1'b1);
    rd_reg(A_C0, d, 1'b1); chk("R11 not locked with one enable", d, 32'h0);
    wr_reg(A_C1, 32'h1, 1'b1);
    wr_reg(A_C0, 32'h7, 1'b1);
    wr_reg(A_C0, 32'h4, 1'b1);
    rd_reg(A_C0, d, 1'b1); chk("R11 ctrl0 clear ignored", d, 32'h3);
    wr_reg(A_C1, 32'h0, 1'b1);
    rd_reg(A_C1, d, 1'b1); chk("R11 ctrl1 clear ignored", d, 32'h1);
    pulse_sys();
    rd_reg(A_C0, d, 1'b1); chk("R12 lock released by reset", d, 32'h0);

    repeat (300) @(posedge clk);
    chk("R5 all expected events seen", 32'(q.size()), 32'h0);
    finish_run();
  end
endmodule